// File: doc/BRIEF.md
# Segment LCD Frame Memory and Scan Driver

This block stores the pixel image of a multiplexed segment LCD for up to eight common (COM) lines, with 64 bits per line. Software reaches the image through a small word-addressed register bus, as a low and a high 32-bit word per line. The scan logic never reads the image directly. It reads a shadow copy. Software asks for a new image to be shown by setting a request flag. The whole image is then copied into the shadow at the next frame strobe, and a done flag is raised. While the request is pending, writes to the image are dropped. This keeps a half-written picture from ever reaching the glass.

Each clock, an external timing source gives the current COM phase index and a blink half-period flag. The block answers one cycle later with registered outputs:
- a one-hot vector of active physical COM pins;
- the on/off state of every segment pin for that phase.

Blink masking, the pin remap option and the eight-line mode are applied on the way out. In eight-line mode the top four segment pins act as COM lines 4 to 7. Analog drive levels are handled elsewhere.

Register map (bus_addr):
- 0: control. Bit 0 enables the scan, bits 3:1 select the duty, bit 4 turns on the remap, and bits 6:5 select the blink mode.
- 1: status. On read, bit 0 is the request flag, bit 1 is the done flag and bit 2 is the running flag. On write, bit 0 = 1 sets the request and bit 1 = 1 clears the done flag.
- 16 + 2·c: low word (image bits 31:0) of line c.
- 17 + 2·c: high word (image bits 63:32) of line c.
- Any other address reads as 0.

bus_rdata is registered and shows the word addressed on the previous clock edge.

Top module: `lcd_frame_ram`

## Requirements
- R1: The duty field (control bits 3:1) sets the number of active COM lines: 000 = 1, 001 = 2, 010 = 3, 011 = 4, 100 = 8, and any other code = 1. When the phase index is at or above that number, both com_on and seg_on are all zero. For phases 0 to 3, com_on is one-hot at bit `phase`.
- R2: Each line's 64-bit image can be written and read back as a low word (bits 31:0, address 16+2c) and a high word (bits 63:32, address 17+2c). Read data appears one cycle after the address.
- R3: While the request flag is set, image writes are ignored. The stored word keeps its old value.
- R4: On the first frame_strobe cycle while the request flag is set, three things happen in the same cycle: the image is copied into the shadow, the request flag clears and the done flag sets. The shadow changes at no other time.
- R5: Writing 1 to status bit 1 clears the done flag. Writing 0 there leaves it unchanged.
- R6: In eight-line mode, com_on is zero for phases 4 to 7. For those phases, segment pin NSEG-4+(phase-4) is driven high, and the usable pixel count becomes NSEG-4.
- R7: With remap set, pins 31:28 show image bits 43:40, and pins 43:40 are off.
- R8: While blink_off is high, the blink mode (control bits 6:5) forces pixels off: 00 = none, 01 = bit 0 in phase 0 only, 10 = bit 0 in every phase, 11 = all pixels. While blink_off is low, the image shows unchanged.
- R9: Segment pins at or above the usable pixel count never show image bits.
- R10: The running flag follows the enable bit one cycle later. While it is low, com_on and seg_on are zero, and after reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| frame_strobe | input | 1 | Frame boundary pulse |
| phase | input | 3 | Current COM phase index |
| blink_off | input | 1 | High in the blink-off half period |
| com_on | output | 4 | One-hot active physical COM pin |
| seg_on | output | NSEG | Segment pin on/off for this phase |
| upd_req | output | 1 | Update request pending |
| upd_done | output | 1 | Update completed, cleared by writing 1 |
| running | output | 1 | Scan enabled status |

## Verification
The assertions assume that frame_strobe and phase are meaningful on every clock. The shadow-stability and request-to-done properties rely only on the register bus, and hold for any stimulus. The eight-line exclusivity property assumes that duty is not rewritten in the same cycle it is checked. The bench satisfies this by changing the control word only between phase sweeps, followed by an idle cycle. The bench programs the image fully before the first commit, so no undefined memory word reaches the shadow.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;
  localparam int NCOM = 8;
  localparam int COM_PINS = 4;

  // control word as held in register 0
  typedef struct packed {
    logic [1:0] blink;
    logic       remap;
    logic [2:0] duty;
    logic       en;
  } ctrl_t;

  function automatic logic [3:0] ncom_of(input logic [2:0] duty);
    case (duty)
      3'd0: ncom_of = 4'd1;
      3'd1: ncom_of = 4'd2;
      3'd2: ncom_of = 4'd3;
      3'd3: ncom_of = 4'd4;
      3'd4: ncom_of = 4'd8;
      default: ncom_of = 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/lcdr_ctrl.sv
module lcdr_ctrl
  import lcdr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [4:0]  addr,
  input  logic [6:0]  wdata,
  input  logic        frame_strobe,
  output ctrl_t       ctrl,
  output logic        req,
  output logic        done,
  output logic        run,
  output logic        commit
);
  logic st_wr;
  assign st_wr  = we && (addr == 5'd1);
  assign commit = req && frame_strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      req  <= 1'b0;
      done <= 1'b0;
      run  <= 1'b0;
    end else begin
      run <= ctrl.en;
      if (we && addr == 5'd0) ctrl <= ctrl_t'(wdata);
      if (commit) begin
        req  <= 1'b0;
        done <= 1'b1;
      end else begin
        if (st_wr && wdata[0]) req  <= 1'b1;
        if (st_wr && wdata[1]) done <= 1'b0;
      end
    end
  end

  // R4: a pending request only leaves by completing
  a_r4_req_ends_done: assert property (@(posedge clk) disable iff (rst)
    req |=> (req || done));
  // R5: write-one-to-clear takes effect when no commit collides
  a_r5_done_w1c: assert property (@(posedge clk) disable iff (rst)
    (st_wr && wdata[1] && !commit) |=> !done);
endmodule

// File: rtl/lcdr_image.sv
module lcdr_image
  import lcdr_pkg::*;
#(
  parameter int SEG_W = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [4:0]                  addr,
  input  logic [31:0]                 wdata,
  input  logic                        req,
  input  logic                        commit,
  output logic [31:0]                 rd_word,
  output logic [NCOM-1:0][SEG_W-1:0]  shadow
);
  localparam int NWORD = 2 * NCOM;
  localparam int AW    = $clog2(NWORD);

  logic [31:0] mem [NWORD];

  // image store: no reset so it maps to a RAM
  always_ff @(posedge clk) begin
    if (we && addr[4] && !req) mem[addr[AW-1:0]] <= wdata;
    rd_word <= mem[addr[AW-1:0]];
  end

  for (genvar c = 0; c < NCOM; c++) begin : g_sh
    always_ff @(posedge clk) begin
      if (rst)         shadow[c] <= '0;
      else if (commit) shadow[c] <= {mem[2*c+1], mem[2*c]};
    end
  end

  // R4: the shadow moves only on a commit
  a_r4_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(shadow));
endmodule

// File: rtl/lcdr_scan.sv
module lcdr_scan
  import lcdr_pkg::*;
#(
  parameter int SEG_W = 64,
  parameter int NSEG  = 52
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        run,
  input  ctrl_t                       ctrl,
  input  logic [NCOM-1:0][SEG_W-1:0]  shadow,
  input  logic [2:0]                  phase,
  input  logic                        blink_off,
  output logic [COM_PINS-1:0]         com_on,
  output logic [NSEG-1:0]             seg_on
);
  logic [SEG_W-1:0]    px, tmp;
  logic [NSEG-1:0]     segv;
  logic [COM_PINS-1:0] comv;
  logic [3:0]          ncom;
  logic                eight, live;
  int                  nseg_eff;

  always_comb begin
    ncom     = ncom_of(ctrl.duty);
    eight    = (ctrl.duty == 3'd4);
    nseg_eff = eight ? NSEG - 4 : NSEG;
    live     = run && ({1'b0, phase} < ncom);
    px       = shadow[phase];
    if (blink_off) begin
      case (ctrl.blink)
        2'd1: if (phase == 3'd0) px[0] = 1'b0;
        2'd2: px[0] = 1'b0;
        2'd3: px = '0;
        default: ;
      endcase
    end
    tmp = px;
    if (ctrl.remap) begin
      px[31:28] = tmp[43:40];
      px[43:40] = 4'b0;
    end
    segv = '0;
    for (int i = 0; i < NSEG; i++)
      if (i < nseg_eff) segv[i] = px[i];
    if (eight && phase[2]) segv[NSEG-4+int'(phase[1:0])] = 1'b1;
    comv = phase[2] ? '0 : (COM_PINS'(1) << phase[1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst || !live) begin
      com_on <= '0;
      seg_on <= '0;
    end else begin
      com_on <= comv;
      seg_on <= segv;
    end
  end

  // R1: at most one physical COM pin active
  a_r1_com_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(com_on));
  // R10: nothing is driven when the scan is stopped
  a_r10_idle_dark: assert property (@(posedge clk) disable iff (rst)
    !run |=> (com_on == '0 && seg_on == '0));
  // R6: COM lines 4..7 on segment pins never coincide with a real COM pin
  a_r6_com_exclusive: assert property (@(posedge clk) disable iff (rst)
    (eight && $stable(ctrl)) |=> !((|com_on) && (|seg_on[NSEG-1:NSEG-4] ) && $past(eight)));
endmodule

// File: rtl/lcd_frame_ram.sv
module lcd_frame_ram
  import lcdr_pkg::*;
#(
  parameter int SEG_W = 64,
  parameter int NSEG  = 52
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_we,
  input  logic [4:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                frame_strobe,
  input  logic [2:0]          phase,
  input  logic                blink_off,
  output logic [3:0]          com_on,
  output logic [NSEG-1:0]     seg_on,
  output logic                upd_req,
  output logic                upd_done,
  output logic                running
);
  ctrl_t                       ctrl;
  logic                        commit;
  logic [31:0]                 rd_word, reg_q;
  logic                        sel_ram;
  logic [NCOM-1:0][SEG_W-1:0]  shadow;

  lcdr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata[6:0]), .frame_strobe(frame_strobe),
    .ctrl(ctrl), .req(upd_req), .done(upd_done), .run(running),
    .commit(commit)
  );

  lcdr_image #(.SEG_W(SEG_W)) u_img (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .req(upd_req), .commit(commit),
    .rd_word(rd_word), .shadow(shadow)
  );

  lcdr_scan #(.SEG_W(SEG_W), .NSEG(NSEG)) u_scan (
    .clk(clk), .rst(rst), .run(running), .ctrl(ctrl), .shadow(shadow),
    .phase(phase), .blink_off(blink_off), .com_on(com_on), .seg_on(seg_on)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q   <= '0;
      sel_ram <= 1'b0;
    end else begin
      sel_ram <= bus_addr[4];
      case (bus_addr)
        5'd0:    reg_q <= {25'd0, ctrl};
        5'd1:    reg_q <= {29'd0, running, upd_done, upd_req};
        default: reg_q <= '0;
      endcase
    end
  end

  assign bus_rdata = sel_ram ? rd_word : reg_q;
endmodule

// File: tb/sim_lcd_frame_ram.sv
module sim_lcd_frame_ram;
  localparam int NSEG = 52;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_we = 1'b0;
  logic [4:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            frame_strobe = 1'b0;
  logic [2:0]      phase = '0;
  logic            blink_off = 1'b0;
  logic [3:0]      com_on;
  logic [NSEG-1:0] seg_on;
  logic            upd_req, upd_done, running;

  int checks = 0;
  int fails  = 0;
  logic [63:0] img [8];
  logic [31:0] rd;

  always #4 clk = ~clk;

  lcd_frame_ram #(.SEG_W(64), .NSEG(NSEG)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_strobe(frame_strobe),
    .phase(phase), .blink_off(blink_off), .com_on(com_on), .seg_on(seg_on),
    .upd_req(upd_req), .upd_done(upd_done), .running(running)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdw(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic int ncom_f(input int duty);
    if (duty <= 3) return duty + 1;
    if (duty == 4) return 8;
    return 1;
  endfunction

  function automatic logic [NSEG-1:0] exp_seg(input int duty, input bit remap, input int sel,
                                               input bit boff, input int ph);
    logic [63:0] p, t;
    logic [NSEG-1:0] r;
    int lim;
    if (ph >= ncom_f(duty)) return '0;
    p = img[ph];
    if (boff && sel == 1 && ph == 0) p[0] = 1'b0;
    if (boff && sel == 2) p[0] = 1'b0;
    if (boff && sel == 3) p = '0;
    t = p;
    if (remap) begin p[31:28] = t[43:40]; p[43:40] = 4'b0; end
    lim = (duty == 4) ? NSEG - 4 : NSEG;
    r = '0;
    for (int i = 0; i < lim; i++) r[i] = p[i];
    if (duty == 4 && ph >= 4) r[NSEG - 8 + ph] = 1'b1;
    return r;
  endfunction

  function automatic logic [3:0] exp_com(input int duty, input int ph);
    if (ph >= ncom_f(duty) || ph >= 4) return 4'b0;
    return 4'b1 << ph;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10 reset state
    chk(com_on == 0 && seg_on == 0, "R10 reset outputs", {4'b0, com_on}, 0);
    chk({running, upd_done, upd_req} == 0, "R10 reset flags", {running, upd_done, upd_req}, 0);

    // R2 load image and read it back
    for (int c = 0; c < 8; c++) begin
      img[c][31:0]  = (32'h9E37_79B1 * (c + 1)) | 32'h1;
      img[c][63:32] = (32'hC2B2_AE35 ^ (c << 12)) | 32'hFFF0_0000 | (32'(c + 3) << 8);
      wr(5'(16 + 2 * c), img[c][31:0]);
      wr(5'(17 + 2 * c), img[c][63:32]);
    end
    for (int c = 0; c < 8; c++) begin
      rdw(5'(16 + 2 * c), rd);
      chk(rd == img[c][31:0], "R2 low word", rd, img[c][31:0]);
      rdw(5'(17 + 2 * c), rd);
      chk(rd == img[c][63:32], "R2 high word", rd, img[c][63:32]);
    end

    // R4 request, R3 writes blocked while pending
    wr(5'd1, 32'h1);
    chk(upd_req == 1'b1, "R4 request set", upd_req, 1);
    wr(5'd16, 32'hDEAD_BEEF);
    wr(5'd19, 32'h0BAD_F00D);
    rdw(5'd16, rd);
    chk(rd == img[0][31:0], "R3 low write ignored", rd, img[0][31:0]);
    rdw(5'd19, rd);
    chk(rd == img[1][63:32], "R3 high write ignored", rd, img[1][63:32]);
    chk(upd_req && !upd_done, "R4 waits for strobe", {upd_done, upd_req}, 2'b01);
    frame_strobe = 1'b1;
    @(posedge clk); @(negedge clk);
    frame_strobe = 1'b0;
    chk(!upd_req && upd_done, "R4 commit flags", {upd_done, upd_req}, 2'b10);
    rdw(5'd1, rd);
    chk(rd[1:0] == 2'b10, "R4 status read", rd, 2);

    // R5 done clearing
    wr(5'd1, 32'h0);
    chk(upd_done == 1'b1, "R5 write 0 keeps done", upd_done, 1);
    wr(5'd1, 32'h2);
    chk(upd_done == 1'b0, "R5 W1C clears done", upd_done, 0);

    // R1 R6 R7 R8 R9 sweep
    for (int duty = 0; duty < 6; duty++)
      for (int rm = 0; rm < 2; rm++)
        for (int sel = 0; sel < 4; sel++) begin
          wr(5'd0, 32'((sel << 5) | (rm << 4) | (duty << 1) | 1));
          @(posedge clk); @(negedge clk);
          for (int ph = 0; ph < 8; ph++)
            for (int bo = 0; bo < 2; bo++) begin
              phase = 3'(ph); blink_off = bo[0];
              @(posedge clk); @(negedge clk);
              chk(com_on == exp_com(duty, ph), "R1 R6 com_on", 64'(com_on), 64'(exp_com(duty, ph)));
              chk(seg_on == exp_seg(duty, rm[0], sel, bo[0], ph), "R7 R8 R9 seg_on",
                  64'(seg_on), 64'(exp_seg(duty, rm[0], sel, bo[0], ph)));
            end
        end
    chk(running == 1'b1, "R10 running while enabled", running, 1);

    // R10 disable
    phase = 3'd0; blink_off = 1'b0;
    wr(5'd0, 32'h0);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk(running == 1'b0, "R10 running cleared", running, 0);
    chk(com_on == 0 && seg_on == 0, "R10 dark when disabled", 64'(seg_on), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule